// File: doc/BRIEF.md
# Frame Phase Aligner

The block generates a local frame pulse and a slot count that must stay in phase with a reference frame pulse arriving from another clock domain. The reference is synchronised into the local clock and edge-detected. The first reference edge after reset aligns the local frame, with no alarm. After that, every reference edge is compared with the local frame start. An edge that arrives at the frame start leaves the counter alone. An edge that arrives anywhere else means phase lock is lost. The block then re-aligns the frame, sets a sticky alarm and marks the frame that follows as errored.

Re-aligning moves the frame pulse and the slot count in the same cycle. This makes the framing of any data driven from the slot count jump as well. A memory write that lands in that one correction cycle could go to a wrong address. The block therefore exposes the correction cycle and suppresses any write requested during it. The requester sees a stall and repeats the write. Address and data pass through unchanged.

Top module: `frame_phase_aligner`

## Requirements
- R1: While reset is held, and right after it is released: slot_o is 0, fp_o is 1, and corr_o, locked_o, alarm_o and err_frame_o are all 0.
- R2: With no correction, slot_o steps by one each clock and wraps from FRAME_LEN-1 to 0. fp_o is high exactly when slot_o is 0.
- R3: On the first detected reference edge after reset, if slot_o is not 0, corr_o is high for that one cycle and slot_o is 1 on the next cycle. locked_o rises after the first detected edge whether or not a correction was made. This first correction never sets alarm_o or err_frame_o.
- R4: A detected reference edge that arrives while slot_o is 0 causes no correction.
- R5: A reference edge is detected SYNC_STAGES cycles after the first cycle in which ref_fp_i is high. When the frame is aligned, fp_o is therefore high exactly SYNC_STAGES cycles after that first high cycle of ref_fp_i.
- R6: When locked_o is 1, a detected edge with slot_o not 0 gives a one-cycle corr_o. slot_o is 1 on the next cycle, and alarm_o is set on the next cycle.
- R7: After a correction made while locked, err_frame_o goes high on the next cycle. It stays high through the cycle in which slot_o is FRAME_LEN-1, for FRAME_LEN-1 cycles in all, so exactly one frame is marked.
- R8: alarm_o stays set until alarm_clr_i is sampled high at a clock edge. If a clear and a correction made while locked fall on the same edge, the alarm is set.
- R9: mem_we_o follows wr_req_i except in a cycle with corr_o high. In that cycle mem_we_o is 0 and wr_stall_o equals wr_req_i. mem_addr_o and mem_data_o always equal wr_addr_i and wr_data_i.
- R10: A reference pulse that stays high for several cycles is detected once, at its rising edge.
- R11: A reset in mid-run clears the lock and the alarm. The next detected edge is then handled as an initial alignment, which does not set the alarm.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_fp_i | input | 1 | Reference frame pulse, asynchronous |
| alarm_clr_i | input | 1 | Clears the sticky alarm when high |
| wr_req_i | input | 1 | Memory write request |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| fp_o | output | 1 | Generated frame pulse |
| slot_o | output | CNT_W | Slot position within the frame |
| corr_o | output | 1 | Marks the correction cycle |
| err_frame_o | output | 1 | Marks the frame errored by a re-alignment |
| locked_o | output | 1 | Initial alignment has been done |
| alarm_o | output | 1 | Sticky loss-of-lock alarm |
| mem_we_o | output | 1 | Write enable passed on to memory |
| mem_addr_o | output | ADDR_W | Address passed on to memory |
| mem_data_o | output | DATA_W | Data passed on to memory |
| wr_stall_o | output | 1 | Write was held back; repeat it |

## Verification
The bench sends phase slips of different sizes, including a slip of one slot. A design that compared phase against the wrong slot would correct on every frame or would miss the slip. The first alignment after reset, and again after a reset in mid-run, must not raise the alarm. A design that treated it as a slip would flag a false alarm and mark a false errored frame. A reference pulse held high for three cycles checks that the edge detector fires once; a level-sensitive design would correct again. A clear that falls on the same edge as a slip checks the set-over-clear priority. Writes held on across a slip check that exactly the correction cycle is stalled. A guard that is off by one cycle would let the risky write through.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  typedef enum logic {
    ST_ACQ   = 1'b0,
    ST_TRACK = 1'b1
  } lock_state_e;
endpackage

// File: rtl/fpa_ref_sync.sv
module fpa_ref_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= ref_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], ref_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];
  end

  // one-cycle strobe per reference pulse, however long it is held
  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/fpa_frame_cnt.sv
module fpa_frame_cnt #(
  parameter int unsigned FRAME_LEN = 16,
  parameter int unsigned CNT_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             start_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  // load to 1: the detection cycle is taken as slot 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= CNT_W'(1);
    else if (last_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o   = cnt_q;
  assign start_o = (cnt_q == '0);
  assign last_o  = (cnt_q == LAST);
endmodule

// File: rtl/fpa_phase_ctl.sv
module fpa_phase_ctl
  import fpa_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_rise_i,
  input  logic at_start_i,
  input  logic at_last_i,
  input  logic alarm_clr_i,
  output logic corr_o,
  output logic locked_o,
  output logic alarm_o,
  output logic err_frame_o
);
  lock_state_e state_q;
  logic        alarm_q;
  logic        err_q;
  logic        slip;

  assign corr_o = ref_rise_i & ~at_start_i;
  assign slip   = corr_o & (state_q == ST_TRACK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ACQ;
      alarm_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (ref_rise_i) state_q <= ST_TRACK;
      if (slip)             alarm_q <= 1'b1;
      else if (alarm_clr_i) alarm_q <= 1'b0;
      if (slip)           err_q <= 1'b1;
      else if (at_last_i) err_q <= 1'b0;
    end
  end

  assign locked_o    = (state_q == ST_TRACK);
  assign alarm_o     = alarm_q;
  assign err_frame_o = err_q;
endmodule

// File: rtl/fpa_wr_guard.sv
module fpa_wr_guard #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              block_i,
  input  logic              wr_req_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              wr_stall_o
);
  // address is never altered; a risky write is dropped and stalled
  assign mem_we_o   = wr_req_i & ~block_i;
  assign wr_stall_o = wr_req_i & block_i;
  assign mem_addr_o = wr_addr_i;
  assign mem_data_o = wr_data_i;
endmodule

// File: rtl/frame_phase_aligner.sv
module frame_phase_aligner #(
  parameter  int unsigned FRAME_LEN   = 16,
  parameter  int unsigned SYNC_STAGES = 2,
  parameter  int unsigned ADDR_W      = 8,
  parameter  int unsigned DATA_W      = 8,
  localparam int unsigned CNT_W       = (FRAME_LEN > 2) ? $clog2(FRAME_LEN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_fp_i,
  input  logic              alarm_clr_i,
  input  logic              wr_req_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              fp_o,
  output logic [CNT_W-1:0]  slot_o,
  output logic              corr_o,
  output logic              err_frame_o,
  output logic              locked_o,
  output logic              alarm_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              wr_stall_o
);
  logic ref_rise;
  logic at_start;
  logic at_last;
  logic corr;

  fpa_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ref_i  (ref_fp_i),
    .rise_o (ref_rise)
  );

  fpa_frame_cnt #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (corr),
    .cnt_o   (slot_o),
    .start_o (at_start),
    .last_o  (at_last)
  );

  fpa_phase_ctl u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ref_rise_i  (ref_rise),
    .at_start_i  (at_start),
    .at_last_i   (at_last),
    .alarm_clr_i (alarm_clr_i),
    .corr_o      (corr),
    .locked_o    (locked_o),
    .alarm_o     (alarm_o),
    .err_frame_o (err_frame_o)
  );

  fpa_wr_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_guard (
    .block_i    (corr),
    .wr_req_i   (wr_req_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_data_o (mem_data_o),
    .wr_stall_o (wr_stall_o)
  );

  assign fp_o   = at_start;
  assign corr_o = corr;
endmodule

// File: rtl/fpa_checker.sv
module fpa_checker #(
  parameter  int unsigned FRAME_LEN = 16,
  parameter  int unsigned ADDR_W    = 8,
  parameter  int unsigned DATA_W    = 8,
  localparam int unsigned CNT_W     = (FRAME_LEN > 2) ? $clog2(FRAME_LEN) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              alarm_clr_i,
  input logic              wr_req_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              fp_o,
  input logic [CNT_W-1:0]  slot_o,
  input logic              corr_o,
  input logic              err_frame_o,
  input logic              locked_o,
  input logic              alarm_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_data_o,
  input logic              wr_stall_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  a_r2_slot_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !corr_o |=> slot_o == (($past(slot_o) == LAST) ? CNT_W'(0) : $past(slot_o) + CNT_W'(1)));

  a_r2_fp_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_o |=> !fp_o);

  a_r3_load_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_o |=> (slot_o == CNT_W'(1)) && locked_o);

  a_r3_init_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_o && !locked_o && !alarm_o |=> !alarm_o && !err_frame_o);

  a_r4_no_corr_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_o |-> !corr_o);

  a_r6_alarm_on_slip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_o && locked_o |=> alarm_o);

  a_r8_alarm_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o && !alarm_clr_i |=> alarm_o);

  a_r8_alarm_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_o) |-> $past(corr_o && locked_o));

  a_r7_err_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_o && locked_o |=> err_frame_o);

  a_r7_err_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_frame_o && (slot_o == LAST) && !corr_o |=> !err_frame_o);

  a_r9_guard_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_o |-> !mem_we_o && (wr_stall_o == wr_req_i));

  a_r9_guard_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !corr_o |-> (mem_we_o == wr_req_i) && !wr_stall_o);

  a_r9_addr_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_addr_o == wr_addr_i) && (mem_data_o == wr_data_i));
endmodule

bind frame_phase_aligner fpa_checker #(
  .FRAME_LEN (FRAME_LEN),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W)
) u_fpa_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .alarm_clr_i (alarm_clr_i),
  .wr_req_i    (wr_req_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i),
  .fp_o        (fp_o),
  .slot_o      (slot_o),
  .corr_o      (corr_o),
  .err_frame_o (err_frame_o),
  .locked_o    (locked_o),
  .alarm_o     (alarm_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_data_o  (mem_data_o),
  .wr_stall_o  (wr_stall_o)
);

// File: tb/tb_frame_phase_aligner.sv
module tb_frame_phase_aligner;
  localparam int FRAME_LEN = 16;
  localparam int SYNC      = 2;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 8;
  localparam int CNT_W     = 4;
  localparam int NVEC      = 12;

  typedef struct packed {
    logic [7:0] gap;
    logic [7:0] hold;
    logic       clr;
    logic       wr;
    logic [7:0] corr;
    logic       alarm;
    logic [7:0] errf;
    logic [7:0] stall;
  } vec_t;

  // gap, hold, clr, wr | cumulative corrections, alarm, errored frames, stalls
  localparam vec_t VECS [NVEC] = '{
    '{8'd10, 8'd1, 1'b0, 1'b0, 8'd1, 1'b0, 8'd0, 8'd0},
    '{8'd16, 8'd1, 1'b0, 1'b0, 8'd1, 1'b0, 8'd0, 8'd0},
    '{8'd16, 8'd1, 1'b0, 1'b1, 8'd1, 1'b0, 8'd0, 8'd0},
    '{8'd19, 8'd1, 1'b0, 1'b1, 8'd2, 1'b1, 8'd1, 8'd1},
    '{8'd16, 8'd1, 1'b0, 1'b1, 8'd2, 1'b1, 8'd1, 8'd1},
    '{8'd16, 8'd1, 1'b1, 1'b0, 8'd2, 1'b0, 8'd1, 8'd1},
    '{8'd12, 8'd1, 1'b0, 1'b0, 8'd3, 1'b1, 8'd2, 8'd1},
    '{8'd16, 8'd1, 1'b1, 1'b0, 8'd3, 1'b0, 8'd2, 8'd1},
    '{8'd16, 8'd3, 1'b0, 1'b0, 8'd3, 1'b0, 8'd2, 8'd1},
    '{8'd16, 8'd1, 1'b0, 1'b0, 8'd3, 1'b0, 8'd2, 8'd1},
    '{8'd17, 8'd1, 1'b0, 1'b1, 8'd4, 1'b1, 8'd3, 8'd2},
    '{8'd16, 8'd1, 1'b0, 1'b1, 8'd4, 1'b1, 8'd3, 8'd2}
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              ref_fp_i = 1'b0;
  logic              alarm_clr_i = 1'b0;
  logic              wr_req_i = 1'b0;
  logic [ADDR_W-1:0] wr_addr_i = '0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic              fp_o;
  logic [CNT_W-1:0]  slot_o;
  logic              corr_o, err_frame_o, locked_o, alarm_o;
  logic              mem_we_o, wr_stall_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [DATA_W-1:0] mem_data_o;

  int checks = 0;
  int errors = 0;
  bit run = 1'b0;
  bit done = 1'b0;
  int cyc = 0;
  int corr_cnt = 0, errf_cnt = 0, stall_cnt = 0;
  int rise_cyc = 0, fp_cyc = 0;
  bit err_prev = 1'b0;

  always #2.5 clk_i = ~clk_i;

  frame_phase_aligner #(
    .FRAME_LEN(FRAME_LEN), .SYNC_STAGES(SYNC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_fp_i(ref_fp_i), .alarm_clr_i(alarm_clr_i),
    .wr_req_i(wr_req_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .fp_o(fp_o), .slot_o(slot_o), .corr_o(corr_o), .err_frame_o(err_frame_o),
    .locked_o(locked_o), .alarm_o(alarm_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o), .wr_stall_o(wr_stall_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // spec model: edge seen SYNC cycles after input rise (R5)
  logic [CNT_W-1:0] m_slot;
  logic             m_lock, m_alarm, m_err, ref_d;
  logic [SYNC-1:0]  rise_pipe;
  logic             m_seen, m_corr;
  assign m_seen = rise_pipe[SYNC-1];
  assign m_corr = m_seen && (m_slot != '0);

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_slot <= '0; m_lock <= 1'b0; m_alarm <= 1'b0; m_err <= 1'b0;
      ref_d <= 1'b0; rise_pipe <= '0;
    end else begin
      ref_d     <= ref_fp_i;
      rise_pipe <= {rise_pipe[SYNC-2:0], ref_fp_i & ~ref_d};
      m_slot    <= m_corr ? CNT_W'(1) : ((m_slot == CNT_W'(FRAME_LEN-1)) ? '0 : m_slot + CNT_W'(1));
      m_lock    <= m_lock | m_seen;
      if (m_corr && m_lock) m_alarm <= 1'b1;
      else if (alarm_clr_i) m_alarm <= 1'b0;
      if (m_corr && m_lock) m_err <= 1'b1;
      else if (m_slot == CNT_W'(FRAME_LEN-1)) m_err <= 1'b0;
    end
  end

  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i) begin
    if (run) begin
      chk("R2 slot", 32'(slot_o), 32'(m_slot));
      chk("R2 fp", 32'(fp_o), 32'(m_slot == '0));
      chk("R4 corr", 32'(corr_o), 32'(m_corr));
      chk("R3 locked", 32'(locked_o), 32'(m_lock));
      chk("R8 alarm", 32'(alarm_o), 32'(m_alarm));
      chk("R7 err_frame", 32'(err_frame_o), 32'(m_err));
      chk("R9 we", 32'(mem_we_o), 32'(wr_req_i & ~m_corr));
      chk("R9 stall", 32'(wr_stall_o), 32'(wr_req_i & m_corr));
      chk("R9 addr", 32'({mem_addr_o, mem_data_o}), 32'({wr_addr_i, wr_data_i}));
      if (corr_o) corr_cnt++;
      if (wr_stall_o) stall_cnt++;
      if (err_frame_o && !err_prev) errf_cnt++;
      err_prev = err_frame_o;
      if (ref_fp_i && !ref_d) rise_cyc = cyc;
      if (fp_o) fp_cyc = cyc;
    end
  end

  task automatic run_step(input int gap, input int hold, input logic clr,
                          input logic wr, input int idx, inout int prev_hold);
    wr_req_i  = wr;
    wr_addr_i = ADDR_W'(idx * 17 + 5);
    wr_data_i = DATA_W'(idx * 29 + 3);
    repeat (gap - SYNC - 1 - prev_hold) @(posedge clk_i);
    #1;
    ref_fp_i = 1'b1; alarm_clr_i = clr;
    repeat (hold) @(posedge clk_i);
    #1;
    ref_fp_i = 1'b0; alarm_clr_i = 1'b0;
    repeat (SYNC + 1) @(posedge clk_i);
    #1;
    prev_hold = hold;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ph;
    int base;
    repeat (3) @(posedge clk_i);
    run = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 slot", 32'(slot_o), 0);
    chk("R1 fp", 32'(fp_o), 1);
    chk("R1 flags", 32'({corr_o, locked_o, alarm_o, err_frame_o}), 0);
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    ph = 0;

    for (int i = 0; i < NVEC; i++) begin
      run_step(int'(VECS[i].gap), int'(VECS[i].hold), VECS[i].clr, VECS[i].wr, i, ph);
      chk(i == 0 ? "R3 corr count" : "R6 corr count", 32'(corr_cnt), 32'(VECS[i].corr));
      chk("R8 alarm after step", 32'(alarm_o), 32'(VECS[i].alarm));
      chk("R7 errored frames", 32'(errf_cnt), 32'(VECS[i].errf));
      chk("R9 stall count", 32'(stall_cnt), 32'(VECS[i].stall));
      if (i > 0 && VECS[i].corr == VECS[i-1].corr)
        chk(VECS[i].hold > 1 ? "R10 wide pulse latency" : "R5 latency",
            32'(fp_cyc - rise_cyc), 32'(SYNC));
    end
    wr_req_i = 1'b0;

    // R11 reset in mid-run with alarm set
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R11 reset clears", 32'({locked_o, alarm_o, err_frame_o, corr_o}), 0);
    chk("R1 slot after reset", 32'(slot_o), 0);
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    ph = 0;
    base = corr_cnt;
    run_step(10, 1, 1'b0, 1'b0, 20, ph);
    chk("R11 initial corr", 32'(corr_cnt - base), 1);
    chk("R11 no alarm", 32'(alarm_o), 0);
    chk("R11 locked", 32'(locked_o), 1);

    // R8 clear and slip on the same edge: set wins
    repeat (20 - SYNC - 2) @(posedge clk_i);
    #1; ref_fp_i = 1'b1;
    @(posedge clk_i); #1; ref_fp_i = 1'b0;
    @(posedge clk_i); #1; alarm_clr_i = 1'b1;
    @(posedge clk_i); #1; alarm_clr_i = 1'b0;
    chk("R8 set wins", 32'(alarm_o), 1);
    chk("R6 slip corr", 32'(corr_cnt - base), 2);
    repeat (FRAME_LEN + 2) @(posedge clk_i);
    #1;
    chk("R8 sticky", 32'(alarm_o), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule